// File: doc/BRIEF.md
# Indirect SDRAM Configuration Register File

This block holds the control and status words of a four-bank memory controller. Software sees only two words on the register bus. One is an index port that stores the number of an internal register. The other is a data port that reads or writes whichever internal register the stored index selects. The internal set holds:

- two bus error status words with write-one-to-clear behaviour, and an error address word;
- a global configuration word, and a read-only status word;
- refresh, power-management and timing words;
- an ECC setup word and an ECC error status word;
- four bank words.

From each bank word the block decodes a base address, a window size and a valid flag. A small enable state machine follows bit 31 of the configuration word. The state machine has two states:

- `CTL_OFF` is the reset state. The transition "enable" leaves it when the configuration word is written with bit 31 set.
- `CTL_ON` is the enabled state. The transition "disable" leaves it when the configuration word is written with bit 31 clear.

A bank drives its active output only while its valid flag is set and the state machine is in `CTL_ON`. For each bank, an address-hit output flags a probe address that falls inside an active bank's window. A level interrupt reports a nonzero ECC error status.

Top module: `sdram_cfg_regs`

## Requirements
- R1: A write to bus address 0x10 stores bits [7:0] as the internal index, and a read of 0x10 returns that index zero-extended. A write to bus address 0x11 writes the selected register, and a read of 0x11 returns it combinationally. Any other bus address reads 0 and ignores writes.
- R2: After reset the registers hold these values: power management (index 0x34) 0x07C00000, refresh (0x30) 0x05F00000, timing (0x80) 0x00854009 and configuration (0x20) 0x00800000. All other registers, the index, bank_active, bank_hit and ecc_irq are zero.
- R3: The bus error status words at indices 0x00 and 0x08 are write-one-to-clear: each written 1 clears that stored bit, and a write never sets a bit.
- R4: Several registers store only masked write data:
  - refresh (0x30) stores data & 0x3FF80000;
  - timing (0x80) stores data & 0x018FC01F;
  - ECC setup (0x94) stores data & 0x00F00000;
  - each bank word (0x40, 0x44, 0x48, 0x4C for banks 0 to 3) stores data & 0xFFDEE001;
  - power management (0x34) stores (data & 0xF8000000) | 0x07C00000.

  The error address (0x10), configuration (0x20) and ECC error status (0x98) store data unchanged.
- R5: Writing configuration bit 31 as 1 while it was 0 takes the "enable" transition to `CTL_ON` and clears status bit 31. Writing it as 0 while it was 1 takes the "disable" transition to `CTL_OFF` and sets status bit 31. Other configuration writes leave both unchanged.
- R6: Status (index 0x24) bit 30 sets when configuration bit 30 is written from 0 to 1, and clears when it is written from 1 to 0. Bus writes to the status register have no effect.
- R7: Each bank word is decoded as follows: base = word & 0xFF800000, size = 4 MiB << word[19:17], valid = word[0]. bank_active[i] is 1 exactly when bank i is valid and the state is `CTL_ON`.
- R8: ecc_irq rises when the ECC error status (0x98) is written from zero to nonzero. It falls when that status is written from nonzero to zero, and is otherwise unchanged.
- R9: Reading an index that is not listed in R2 to R7 returns 0, and writing such an index changes no register.
- R10: bank_hit[i] is 1 when bank_active[i] is 1 and base_i <= probe_addr < base_i + size_i, evaluated without 32-bit wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | 10 | Register bus word address |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Register bus read data (combinational) |
| probe_addr | input | 32 | Address checked against the bank windows |
| bank_active | output | 4 | Per-bank active (valid and enabled) |
| bank_hit | output | 4 | Per-bank probe address hit |
| ecc_irq | output | 1 | ECC error interrupt level |

## Verification
Directed sequences first read back every reset value. They then write all-ones and all-zeros to each masked register, which separates the correct mask from a wrong one. Enable and disable writes are made with banks both valid and invalid, to tell the state transitions apart from the bank flags. Probe addresses sit one below a window base, at the base, at the last byte and one past the end, which exposes off-by-one and wrap errors in the window compare. A seeded random run of writes to mapped and unmapped indices then checks every register, the active outputs and the interrupt against a bench model after each burst.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;
    localparam int DW    = 32;
    localparam int IDX_W = 8;

    typedef enum logic [0:0] {CTL_OFF = 1'b0, CTL_ON = 1'b1} ctl_state_t;

    localparam logic [IDX_W-1:0] IX_BESR0  = 8'h00;
    localparam logic [IDX_W-1:0] IX_BESR1  = 8'h08;
    localparam logic [IDX_W-1:0] IX_BEAR   = 8'h10;
    localparam logic [IDX_W-1:0] IX_CFG    = 8'h20;
    localparam logic [IDX_W-1:0] IX_STAT   = 8'h24;
    localparam logic [IDX_W-1:0] IX_RFSH   = 8'h30;
    localparam logic [IDX_W-1:0] IX_PMGT   = 8'h34;
    localparam logic [IDX_W-1:0] IX_TIME   = 8'h80;
    localparam logic [IDX_W-1:0] IX_ECCCFG = 8'h94;
    localparam logic [IDX_W-1:0] IX_ECCERR = 8'h98;

    localparam logic [DW-1:0] MSK_RFSH   = 32'h3FF8_0000;
    localparam logic [DW-1:0] MSK_TIME   = 32'h018F_C01F;
    localparam logic [DW-1:0] MSK_ECCCFG = 32'h00F0_0000;
    localparam logic [DW-1:0] MSK_BANK   = 32'hFFDE_E001;
    localparam logic [DW-1:0] MSK_PMGT   = 32'hF800_0000;
    localparam logic [DW-1:0] FIX_PMGT   = 32'h07C0_0000;

    localparam logic [DW-1:0] RST_PMGT = 32'h07C0_0000;
    localparam logic [DW-1:0] RST_RFSH = 32'h05F0_0000;
    localparam logic [DW-1:0] RST_TIME = 32'h0085_4009;
    localparam logic [DW-1:0] RST_CFG  = 32'h0080_0000;

    // Bank words sit at 0x40 + 4*n
    function automatic logic idx_is_bank(input logic [IDX_W-1:0] ix);
        return (ix[7:4] == 4'h4) && (ix[1:0] == 2'b00);
    endfunction
endpackage

// File: rtl/ctl_fsm.sv
module ctl_fsm
    import sdram_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_bit,
    output logic enabled,
    output logic go_on,
    output logic go_off
);
    ctl_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_OFF: if (cfg_wr && cfg_bit)  state_d = CTL_ON;
            CTL_ON:  if (cfg_wr && !cfg_bit) state_d = CTL_OFF;
            default: state_d = CTL_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CTL_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        enabled = (state_q == CTL_ON);
        go_on   = (state_q == CTL_OFF) && (state_d == CTL_ON);
        go_off  = (state_q == CTL_ON)  && (state_d == CTL_OFF);
    end

    assert_enable_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_bit) |=> enabled);
    assert_disable_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_bit) |=> !enabled);
    assert_hold_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(enabled));
endmodule

// File: rtl/bank_window.sv
module bank_window
    import sdram_cfg_pkg::*;
#(
    parameter int AW = 32
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] word,
    input  logic          enabled,
    input  logic [AW-1:0] probe,
    output logic          active,
    output logic          hit
);
    localparam int    XW        = AW + 1;
    localparam logic [XW-1:0] UNIT = XW'(32'h0040_0000);

    logic [XW-1:0] base_x, size_x, end_x, probe_x;

    always_comb begin
        base_x  = XW'(word & 32'hFF80_0000);
        size_x  = UNIT << word[19:17];
        end_x   = base_x + size_x;
        probe_x = XW'(probe);
        active  = word[0] && enabled;
        hit     = active && (probe_x >= base_x) && (probe_x < end_x);
    end

    assert_hit_needs_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (active && enabled));
endmodule

// File: rtl/ecc_irq_gen.sv
module ecc_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic esr_wr,
    input  logic old_nz,
    input  logic new_nz,
    output logic irq
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (esr_wr) begin
            if (!old_nz && new_nz)      irq_q <= 1'b1;
            else if (old_nz && !new_nz) irq_q <= 1'b0;
        end
    end

    assign irq = irq_q;

    assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(esr_wr && new_nz));
    assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(esr_wr && !new_nz));
endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
    import sdram_cfg_pkg::*;
#(
    parameter int BUS_AW    = 10,
    parameter int NBANK     = 4,
    parameter int PROBE_W   = 32,
    parameter logic [BUS_AW-1:0] IDX_PORT  = 10'h010,
    parameter logic [BUS_AW-1:0] DATA_PORT = 10'h011
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [PROBE_W-1:0] probe_addr,
    output logic [NBANK-1:0]  bank_active,
    output logic [NBANK-1:0]  bank_hit,
    output logic              ecc_irq
);
    localparam int BSEL_W = (NBANK > 1) ? $clog2(NBANK) : 1;

    logic [IDX_W-1:0] idx_q;
    logic [DW-1:0] besr0_q, besr1_q, bear_q, cfg_q, stat_q;
    logic [DW-1:0] rfsh_q, pmgt_q, time_q, ecccfg_q, eccerr_q;
    logic [DW-1:0] bank_q [NBANK];

    logic idx_wr, dat_wr, cfg_wr, esr_wr;
    logic enabled, go_on, go_off;
    logic [BSEL_W-1:0] bsel;
    logic bank_idx;

    always_comb begin
        idx_wr   = bus_wr && (bus_addr == IDX_PORT);
        dat_wr   = bus_wr && (bus_addr == DATA_PORT);
        cfg_wr   = dat_wr && (idx_q == IX_CFG);
        esr_wr   = dat_wr && (idx_q == IX_ECCERR);
        bsel     = BSEL_W'(idx_q[3:2]);
        bank_idx = idx_is_bank(idx_q) && (32'(idx_q[3:2]) < NBANK);
    end

    ctl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (cfg_wr),
        .cfg_bit (bus_wdata[31]),
        .enabled (enabled),
        .go_on   (go_on),
        .go_off  (go_off)
    );

    ecc_irq_gen u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .esr_wr (esr_wr),
        .old_nz (eccerr_q != '0),
        .new_nz (bus_wdata != '0),
        .irq    (ecc_irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            besr0_q  <= '0;
            besr1_q  <= '0;
            bear_q   <= '0;
            cfg_q    <= RST_CFG;
            stat_q   <= '0;
            rfsh_q   <= RST_RFSH;
            pmgt_q   <= RST_PMGT;
            time_q   <= RST_TIME;
            ecccfg_q <= '0;
            eccerr_q <= '0;
        end else begin
            if (idx_wr) idx_q <= bus_wdata[IDX_W-1:0];
            if (go_on)  stat_q[31] <= 1'b0;
            if (go_off) stat_q[31] <= 1'b1;
            if (cfg_wr) begin
                if (!cfg_q[30] && bus_wdata[30])      stat_q[30] <= 1'b1;
                else if (cfg_q[30] && !bus_wdata[30]) stat_q[30] <= 1'b0;
            end
            if (dat_wr) begin
                unique case (idx_q)
                    IX_BESR0:  besr0_q  <= besr0_q & ~bus_wdata;
                    IX_BESR1:  besr1_q  <= besr1_q & ~bus_wdata;
                    IX_BEAR:   bear_q   <= bus_wdata;
                    IX_CFG:    cfg_q    <= bus_wdata;
                    IX_RFSH:   rfsh_q   <= bus_wdata & MSK_RFSH;
                    IX_PMGT:   pmgt_q   <= (bus_wdata & MSK_PMGT) | FIX_PMGT;
                    IX_TIME:   time_q   <= bus_wdata & MSK_TIME;
                    IX_ECCCFG: ecccfg_q <= bus_wdata & MSK_ECCCFG;
                    IX_ECCERR: eccerr_q <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[b] <= '0;
            else if (dat_wr && bank_idx && (bsel == BSEL_W'(b)))
                bank_q[b] <= bus_wdata & MSK_BANK;
        end

        bank_window #(.AW(PROBE_W)) u_win (
            .clk     (clk),
            .rst_n   (rst_n),
            .word    (bank_q[b]),
            .enabled (enabled),
            .probe   (probe_addr),
            .active  (bank_active[b]),
            .hit     (bank_hit[b])
        );
    end

    logic [DW-1:0] sel_data;
    always_comb begin
        sel_data = '0;
        unique case (idx_q)
            IX_BESR0:  sel_data = besr0_q;
            IX_BESR1:  sel_data = besr1_q;
            IX_BEAR:   sel_data = bear_q;
            IX_CFG:    sel_data = cfg_q;
            IX_STAT:   sel_data = stat_q;
            IX_RFSH:   sel_data = rfsh_q;
            IX_PMGT:   sel_data = pmgt_q;
            IX_TIME:   sel_data = time_q;
            IX_ECCCFG: sel_data = ecccfg_q;
            IX_ECCERR: sel_data = eccerr_q;
            default:   if (bank_idx) sel_data = bank_q[bsel];
        endcase
        if (bus_addr == IDX_PORT)       bus_rdata = DW'(idx_q);
        else if (bus_addr == DATA_PORT) bus_rdata = sel_data;
        else                            bus_rdata = '0;
    end

    assert_status_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[31]) |-> $fell(enabled));
    assert_status_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_q[31]) |-> $rose(enabled));
    assert_status_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(stat_q));
    assert_active_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_active != '0) |-> enabled);
    assert_besr_no_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(besr0_q) <= $countones($past(besr0_q))));
endmodule

// File: tb/test_sdram_cfg_regs.sv
module test_sdram_cfg_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] probe_addr = '0;
    logic [3:0]  bank_active, bank_hit;
    logic        ecc_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sdram_cfg_regs i_sdram_cfg_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .probe_addr(probe_addr),
        .bank_active(bank_active), .bank_hit(bank_hit), .ecc_irq(ecc_irq)
    );

    // bench model
    logic [7:0]  m_idx;
    logic [31:0] m_besr0, m_besr1, m_bear, m_cfg, m_stat, m_rfsh, m_pmgt, m_time, m_ecfg, m_eerr;
    logic [31:0] m_bank [4];
    logic        m_irq;

    task automatic model_reset();
        m_idx = 0; m_besr0 = 0; m_besr1 = 0; m_bear = 0; m_cfg = 32'h0080_0000;
        m_stat = 0; m_rfsh = 32'h05F0_0000; m_pmgt = 32'h07C0_0000;
        m_time = 32'h0085_4009; m_ecfg = 0; m_eerr = 0; m_irq = 0;
        for (int i = 0; i < 4; i++) m_bank[i] = 0;
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] ix);
        case (ix)
            8'h00: return m_besr0;
            8'h08: return m_besr1;
            8'h10: return m_bear;
            8'h20: return m_cfg;
            8'h24: return m_stat;
            8'h30: return m_rfsh;
            8'h34: return m_pmgt;
            8'h40: return m_bank[0];
            8'h44: return m_bank[1];
            8'h48: return m_bank[2];
            8'h4C: return m_bank[3];
            8'h80: return m_time;
            8'h94: return m_ecfg;
            8'h98: return m_eerr;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(input logic [7:0] ix, input logic [31:0] v);
        case (ix)
            8'h00: m_besr0 &= ~v;
            8'h08: m_besr1 &= ~v;
            8'h10: m_bear = v;
            8'h20: begin
                if (!m_cfg[31] && v[31]) m_stat[31] = 1'b0;
                if (m_cfg[31] && !v[31]) m_stat[31] = 1'b1;
                if (!m_cfg[30] && v[30]) m_stat[30] = 1'b1;
                if (m_cfg[30] && !v[30]) m_stat[30] = 1'b0;
                m_cfg = v;
            end
            8'h30: m_rfsh = v & 32'h3FF8_0000;
            8'h34: m_pmgt = (v & 32'hF800_0000) | 32'h07C0_0000;
            8'h40: m_bank[0] = v & 32'hFFDE_E001;
            8'h44: m_bank[1] = v & 32'hFFDE_E001;
            8'h48: m_bank[2] = v & 32'hFFDE_E001;
            8'h4C: m_bank[3] = v & 32'hFFDE_E001;
            8'h80: m_time = v & 32'h018F_C01F;
            8'h94: m_ecfg = v & 32'h00F0_0000;
            8'h98: begin
                if (m_eerr == 0 && v != 0) m_irq = 1'b1;
                if (m_eerr != 0 && v == 0) m_irq = 1'b0;
                m_eerr = v;
            end
            default: ;
        endcase
    endtask

    function automatic logic [3:0] exp_active();
        logic [3:0] r;
        for (int i = 0; i < 4; i++) r[i] = m_bank[i][0] && m_cfg[31];
        return r;
    endfunction

    function automatic logic [3:0] exp_hit(input logic [31:0] a);
        logic [3:0] r;
        logic [32:0] b, e;
        for (int i = 0; i < 4; i++) begin
            b = {1'b0, m_bank[i] & 32'hFF80_0000};
            e = b + (33'h0040_0000 << m_bank[i][19:17]);
            r[i] = m_bank[i][0] && m_cfg[31] && ({1'b0, a} >= b) && ({1'b0, a} < e);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] ix, input logic [31:0] v);
        bus_write(10'h010, {24'h0, ix});
        bus_write(10'h011, v);
        m_idx = ix;
        model_write(ix, v);
    endtask

    task automatic reg_read(input logic [7:0] ix, output logic [31:0] v);
        bus_write(10'h010, {24'h0, ix});
        m_idx = ix;
        bus_addr = 10'h011;
        #1 v = bus_rdata;
    endtask

    task automatic check_reg(input string req, input logic [7:0] ix);
        logic [31:0] v;
        reg_read(ix, v);
        check(req, v, model_read(ix));
    endtask

    task automatic check_all(input string req);
        logic [7:0] list [14] = '{8'h00, 8'h08, 8'h10, 8'h20, 8'h24, 8'h30, 8'h34,
                                  8'h40, 8'h44, 8'h48, 8'h4C, 8'h80, 8'h94, 8'h98};
        for (int i = 0; i < 14; i++) check_reg(req, list[i]);
        check({req, " active"}, {28'h0, bank_active}, {28'h0, exp_active()});
        check({req, " irq"}, {31'h0, ecc_irq}, {31'h0, m_irq});
    endtask

    task automatic probe(input string req, input logic [31:0] a);
        probe_addr = a;
        #1 check(req, {28'h0, bank_hit}, {28'h0, exp_hit(a)});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic [7:0]  ix_pool [18] = '{8'h00, 8'h08, 8'h10, 8'h20, 8'h24, 8'h30, 8'h34,
                                     8'h40, 8'h44, 8'h48, 8'h4C, 8'h80, 8'h94, 8'h98,
                                     8'h04, 8'h50, 8'h41, 8'hFF};
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R2 reset state
        check("R2 index", bus_rdata, 32'h0);
        bus_addr = 10'h010;
        #1 check("R2 index port", bus_rdata, 32'h0);
        check("R2 hit", {28'h0, bank_hit}, 32'h0);
        check_all("R2");

        // R1 index port and other bus addresses
        bus_write(10'h010, 32'hABCD_EF98);
        bus_addr = 10'h010;
        #1 check("R1 index readback", bus_rdata, 32'h0000_0098);
        bus_write(10'h012, 32'hFFFF_FFFF);
        bus_addr = 10'h012;
        #1 check("R1 other addr reads 0", bus_rdata, 32'h0);
        check_all("R1 other addr write ignored");

        // R3 write-one-to-clear never sets
        reg_write(8'h00, 32'hFFFF_FFFF);
        reg_write(8'h08, 32'h0000_0000);
        check_reg("R3 besr0", 8'h00);
        check_reg("R3 besr1", 8'h08);

        // R4 masks with all-ones and zeros, R11-like plain stores
        reg_write(8'h30, 32'hFFFF_FFFF); check_reg("R4 refresh", 8'h30);
        reg_write(8'h80, 32'hFFFF_FFFF); check_reg("R4 timing", 8'h80);
        reg_write(8'h94, 32'hFFFF_FFFF); check_reg("R4 ecc setup", 8'h94);
        reg_write(8'h34, 32'h0000_0000); check_reg("R4 pmgt zero", 8'h34);
        reg_write(8'h34, 32'hFFFF_FFFF); check_reg("R4 pmgt ones", 8'h34);
        reg_write(8'h44, 32'hFFFF_FFFF); check_reg("R4 bank1", 8'h44);
        reg_write(8'h10, 32'h1234_5678); check_reg("R4 error address", 8'h10);
        check("R7 active while off", {28'h0, bank_active}, 32'h0);

        // R7 / R5 enable with valid banks
        reg_write(8'h40, 32'h0080_0001); // bank0 base 8M size 4M
        reg_write(8'h48, 32'h1000_0000 | (32'd2 << 17)); // bank2 invalid
        reg_write(8'h4C, 32'hFF80_0000 | (32'd7 << 17) | 1); // bank3 at top, 512M
        reg_write(8'h20, 32'h8000_0000);
        check_reg("R5 status after enable", 8'h24);
        check("R7 active on", {28'h0, bank_active}, {28'h0, exp_active()});
        // R10 window boundaries
        probe("R10 below base", 32'h007F_FFFF);
        probe("R10 at base", 32'h0080_0000);
        probe("R10 last byte", 32'h00BF_FFFF);
        probe("R10 past end", 32'h00C0_0000);
        probe("R10 top bank no wrap", 32'hFFFF_FFFF);
        probe("R10 invalid bank", 32'h1000_0000);
        // R6 bit 30 and status write ignored
        reg_write(8'h20, 32'hC000_0000);
        check_reg("R6 status bit30 set", 8'h24);
        reg_write(8'h24, 32'h0000_0000);
        check_reg("R6 status ignores write", 8'h24);
        reg_write(8'h20, 32'h8000_0000);
        check_reg("R6 status bit30 clear", 8'h24);
        // R5 disable
        reg_write(8'h20, 32'h0000_0000);
        check_reg("R5 status after disable", 8'h24);
        check("R5 active off", {28'h0, bank_active}, 32'h0);
        probe("R10 disabled", 32'h0080_0000);

        // R8 ECC interrupt
        reg_write(8'h98, 32'h0000_0010);
        check("R8 rise", {31'h0, ecc_irq}, 32'h1);
        reg_write(8'h98, 32'h0000_0300);
        check("R8 stays", {31'h0, ecc_irq}, 32'h1);
        reg_write(8'h98, 32'h0000_0000);
        check("R8 fall", {31'h0, ecc_irq}, 32'h0);

        // R9 unmapped indices
        reg_write(8'h04, 32'hFFFF_FFFF); check_reg("R9 unmapped read", 8'h04);
        reg_write(8'h41, 32'hFFFF_FFFF); check_reg("R9 odd bank index", 8'h41);
        check_all("R9 no side effect");

        // random bursts
        for (int burst = 0; burst < 25; burst++) begin
            for (int k = 0; k < 12; k++) begin
                logic [31:0] d;
                d = $urandom();
                if ($urandom_range(0, 3) == 0) d = 32'h0;
                reg_write(ix_pool[$urandom_range(0, 17)], d);
            end
            check_all("R1 random");
            for (int p = 0; p < 4; p++) begin
                logic [31:0] a;
                a = (m_bank[p] & 32'hFF80_0000) + ($urandom() & 32'h003F_FFFF);
                probe("R10 random", a);
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule